// File: doc/BRIEF.md
# Dual Potentiometer Serial Front End

This block is the serial control front end of a two-channel digitally controlled potentiometer. A host drives a four-wire serial bus (clock, select, data in, data out) plus a pause line and a write-protect line. Each transfer starts when chip select falls. The first byte is an instruction: bits [7:4] hold the operation code, bits [3:2] the device address and bits [1:0] the potentiometer select. The second byte carries data.

Two volatile wiper registers drive the tap outputs directly. Two non-volatile data registers are written through a timed internal write cycle. That cycle is modelled as a busy interval of `WR_CYCLES` system clocks, and it starts when chip select rises after a valid write frame. All bus pins are brought into the system clock domain through two-flop synchronizers. Every bus event takes effect on the third system clock after the pin changes.

Operation codes: 4'h1 writes the wiper register, 4'h2 writes the non-volatile register, 4'h3 reads the wiper register, 4'h4 reads the non-volatile register and 4'h5 reads status. Read data is returned as a byte with the 6-bit value in bits [5:0]. The status byte carries the busy bit in bit 0.

Top module: `dpot_spi_front`

## Requirements
- R1: Serial input is captured on rising clock edges, most significant bit first, as a 16-bit frame made of the instruction byte {op[3:0], addr[1:0], pot[1:0]} followed by a data byte.
- R2: During the data byte of a matching read, the output is driven (so_en high) and updated on each falling clock edge, most significant bit first. The value is {2'b00, tap} for wiper and non-volatile reads.
- R3: While chip select is high or no matching read is in progress, so_en is low. standby equals chip select high with no internal write cycle running.
- R4: A frame whose address field differs from dev_addr changes no register and never drives the output.
- R5: A wiper write (op 4'h1) updates the addressed tap at the sixteenth rising edge, whatever the level of wp_n. Data values above 63 saturate to 63.
- R6: A non-volatile write (op 4'h2) starts the internal cycle at the rising edge of chip select only if exactly 16 bits were received. busy then stays high for WR_CYCLES clocks, after which the data register holds the saturated value.
- R7: If wp_n is low at any point between chip select falling and rising, the non-volatile write is dropped. Once busy is high, wp_n has no effect.
- R8: While busy is high, both write operations are rejected. A status read returns 8'h01 while busy and 8'h00 otherwise.
- R9: Pause starts when hold_n is low while the clock is low, and ends when hold_n is high while the clock is low. While paused, so_en is low, clock and data transitions are ignored, and the transfer continues from where it stopped.
- R10: A potentiometer select of 2 or 3, or an unknown operation code, has no effect.
- R11: After reset, both taps equal RST_TAP, both data registers are 0, busy is low, standby is high and so_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 2 | Strapped device address |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low write protect for non-volatile writes |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for the so driver (low means high impedance) |
| busy | output | 1 | Internal write cycle running |
| standby | output | 1 | Deselected and idle |
| wiper | output | NPOT*TAP_W | Wiper tap values, pot 0 in the low bits |

## Verification
Each bus pin passes two synchronizer flops, so its edge acts on the third system clock. An so bit is therefore valid three clocks after a falling clock edge, a wiper update appears three clocks after the sixteenth rising edge, and busy rises three clocks after chip select rises and then holds for exactly WR_CYCLES clocks. The bench keeps every serial half period at six system clocks and samples outputs just before the next serial edge, or several clocks after chip select rises. Each sample therefore lands after the change is due and before anything else can move it. The non-volatile contents are checked only after the busy window has fully closed.

// File: rtl/dpot_spi_front.sv
module dpot_spi_front #(
  parameter int NPOT      = 2,
  parameter int TAP_W     = 6,
  parameter int WR_CYCLES = 64,
  parameter int RST_TAP   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              dev_addr,
  input  logic                    sck,
  input  logic                    cs_n,
  input  logic                    si,
  input  logic                    hold_n,
  input  logic                    wp_n,
  output logic                    so,
  output logic                    so_en,
  output logic                    busy,
  output logic                    standby,
  output logic [NPOT*TAP_W-1:0]   wiper
);
  localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1;
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] TAP_MAX8 = 8'((1 << TAP_W) - 1);
  localparam logic [3:0] OP_WR_WIP = 4'h1, OP_WR_NV = 4'h2,
                         OP_RD_WIP = 4'h3, OP_RD_NV = 4'h4, OP_RD_ST = 4'h5;

  logic [4:0] s1, s2;
  logic sck_p, cs_p, paused;
  logic sck_s, cs_s, si_s, hold_s, wp_s;
  logic sck_rise, sck_fall, cs_fall, cs_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 5'b01011; s2 <= 5'b01011; sck_p <= 1'b0; cs_p <= 1'b1;
    end else begin
      s1 <= {sck, cs_n, si, hold_n, wp_n};
      s2 <= s1;
      sck_p <= s2[4];
      cs_p <= s2[3];
    end

  assign {sck_s, cs_s, si_s, hold_s, wp_s} = s2;
  assign sck_rise = sck_s & ~sck_p;
  assign sck_fall = ~sck_s & sck_p;
  assign cs_fall  = ~cs_s & cs_p;
  assign cs_rise  = cs_s & ~cs_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) paused <= 1'b0;
    else if (cs_s) paused <= 1'b0;
    else if (!sck_s) paused <= ~hold_s;

  function automatic logic [TAP_W-1:0] sat(input logic [7:0] d);
    return (d > TAP_MAX8) ? TAP_MAX8[TAP_W-1:0] : d[TAP_W-1:0];
  endfunction

  logic [6:0] sh;
  logic [4:0] bitcnt;
  logic [7:0] byte_in, rd_byte, tx;
  logic [3:0] op_q;
  logic [PW-1:0] pot_q, pot_in, nv_pot, c_pot;
  logic hit_q, hit_in, is_rd, rd_phase, so_r, nv_pend, wp_ok;
  logic [TAP_W-1:0] nv_val, c_val;
  logic [TAP_W-1:0] wip_r [NPOT];
  logic [TAP_W-1:0] nv_r  [NPOT];
  logic [CW-1:0] cnt;

  assign byte_in = {sh, si_s};
  assign pot_in  = byte_in[PW-1:0];
  assign hit_in  = (byte_in[3:2] == dev_addr) && (32'(byte_in[1:0]) < NPOT);
  assign is_rd   = (byte_in[7:4] == OP_RD_WIP) || (byte_in[7:4] == OP_RD_NV) ||
                   (byte_in[7:4] == OP_RD_ST);

  always_comb begin
    rd_byte = '0;
    case (byte_in[7:4])
      OP_RD_WIP: rd_byte[TAP_W-1:0] = wip_r[pot_in];
      OP_RD_NV:  rd_byte[TAP_W-1:0] = nv_r[pot_in];
      OP_RD_ST:  rd_byte[0] = busy;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; bitcnt <= '0; op_q <= '0; pot_q <= '0; hit_q <= 1'b0;
      rd_phase <= 1'b0; tx <= '0; so_r <= 1'b0;
      nv_pend <= 1'b0; nv_val <= '0; nv_pot <= '0; wp_ok <= 1'b0;
      for (int i = 0; i < NPOT; i++) wip_r[i] <= TAP_W'(RST_TAP);
    end else if (cs_fall) begin
      bitcnt <= '0; rd_phase <= 1'b0; hit_q <= 1'b0;
      nv_pend <= 1'b0; wp_ok <= wp_s;
    end else if (!cs_s) begin
      if (!wp_s) wp_ok <= 1'b0;
      if (!paused && sck_rise) begin
        sh <= byte_in[6:0];
        if (bitcnt != 5'd17) bitcnt <= bitcnt + 5'd1;
        if (bitcnt == 5'd7) begin
          op_q <= byte_in[7:4]; pot_q <= pot_in; hit_q <= hit_in;
          if (hit_in && is_rd) begin
            rd_phase <= 1'b1;
            tx <= rd_byte;
          end
        end
        if (bitcnt == 5'd15 && hit_q) begin
          if (op_q == OP_WR_WIP && !busy) wip_r[pot_q] <= sat(byte_in);
          if (op_q == OP_WR_NV) begin
            nv_pend <= 1'b1; nv_val <= sat(byte_in); nv_pot <= pot_q;
          end
        end
        if (bitcnt >= 5'd16) nv_pend <= 1'b0;
      end
      if (!paused && sck_fall && rd_phase) begin
        so_r <= tx[7];
        tx <= {tx[6:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; c_pot <= '0; c_val <= '0;
      for (int i = 0; i < NPOT; i++) nv_r[i] <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        nv_r[c_pot] <= c_val;
      end else cnt <= cnt - 1'b1;
    end else if (cs_rise && nv_pend && wp_ok && wp_s) begin
      busy <= 1'b1;
      cnt <= CW'(WR_CYCLES - 1);
      c_pot <= nv_pot;
      c_val <= nv_val;
    end

  assign so      = so_r;
  assign so_en   = ~cs_s & ~paused & rd_phase;
  assign standby = cs_s & ~busy;

  for (genvar g = 0; g < NPOT; g++) begin : g_tap
    assign wiper[g*TAP_W +: TAP_W] = wip_r[g];
  end
endmodule

// File: rtl/dpot_spi_front_chk.sv
module dpot_spi_front_chk #(
  parameter int NPOT      = 2,
  parameter int TAP_W     = 6,
  parameter int WR_CYCLES = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  so_en,
  input logic                  busy,
  input logic [NPOT*TAP_W-1:0] wiper
);
  logic [2:0] age;
  logic [$clog2(WR_CYCLES + 2):0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      age <= '0; run <= '0;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      run <= busy ? run + 1'b1 : '0;
    end

  AST_SO_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && so_en) |-> !$past(cs_n, 2));                      // R3
  AST_BUSY_FROM_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && $rose(busy)) |-> $past(cs_n, 3));                  // R6
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(run) < WR_CYCLES));                                  // R6
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && $fell(busy)) |-> (32'(run) == WR_CYCLES));        // R6
  AST_TAP_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !$stable(wiper)) |-> !$past(cs_n, 3));             // R5
  AST_TAP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !$stable(wiper)) |-> !$past(busy));                // R8
endmodule

bind dpot_spi_front dpot_spi_front_chk #(.NPOT(NPOT), .TAP_W(TAP_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_en(so_en), .busy(busy), .wiper(wiper));

// File: tb/dpot_spi_front_bench.sv
`timescale 1ns/1ps
module dpot_spi_front_bench;
  localparam int WR = 600;
  localparam int HP = 6;
  localparam logic [1:0] DEV = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic [1:0] dev_addr = DEV;
  wire so, so_en, busy, standby;
  wire [11:0] wiper;
  int total = 0, bad = 0;
  logic [5:0] m_wip [2];
  logic [5:0] m_nv [2];

  always #2 clk = ~clk;

  dpot_spi_front #(.WR_CYCLES(WR)) u_dpot_spi_front (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en), .busy(busy),
    .standby(standby), .wiper(wiper));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] sat(input logic [7:0] d);
    return (d > 8'd63) ? 6'd63 : d[5:0];
  endfunction

  function automatic logic [7:0] ins(input logic [3:0] op, input logic [1:0] a, input logic [1:0] p);
    return {op, a, p};
  endfunction

  task automatic frame(input logic [7:0] ib, input logic [7:0] db, input int nbits,
                       input bit wp_low, input int wp_pulse_at, input int hold_at,
                       output logic [7:0] rd, output int en_cnt);
    logic [15:0] word;
    word = {ib, db};
    rd = '0; en_cnt = 0;
    if (wp_low) wp_n = 1'b0;
    cs_n = 1'b0;
    tick(HP);
    for (int i = 0; i < nbits; i++) begin
      if (i == hold_at) begin
        hold_n = 1'b0;
        tick(HP);
        check("R9 paused so_en", so_en, 0);
        for (int k = 0; k < 2; k++) begin
          si = 1'($urandom);
          sck = 1'b1; tick(4);
          sck = 1'b0; tick(4);
        end
        hold_n = 1'b1;
        tick(HP);
      end
      if (i == wp_pulse_at) wp_n = 1'b0;
      if (i == wp_pulse_at + 2) wp_n = 1'b1;
      si = (i < 16) ? word[15-i] : 1'($urandom);
      tick(HP);
      if (i >= 8 && i < 16) begin
        rd[15-i] = so;
        if (so_en) en_cnt++;
      end
      sck = 1'b1; tick(HP);
      sck = 1'b0;
    end
    tick(HP);
    cs_n = 1'b1;
    tick(8);
    wp_n = 1'b1;
  endtask

  logic [7:0] rd;
  int en;

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_wip[0] = 6'd32; m_wip[1] = 6'd32; m_nv[0] = '0; m_nv[1] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check("R11 reset taps", wiper, {6'd32, 6'd32});
    check("R11 reset busy", busy, 0);
    check("R11 reset standby", standby, 1);
    check("R11 reset so_en", so_en, 0);

    frame(ins(4'h1, DEV, 2'd0), 8'd10, 16, 0, -1, -1, rd, en);
    m_wip[0] = 6'd10;
    check("R1 wiper write frame", wiper, {m_wip[1], m_wip[0]});
    frame(ins(4'h3, DEV, 2'd0), 8'h00, 16, 0, -1, -1, rd, en);
    check("R2 read wiper byte", rd, 8'h0A);
    check("R2 so_en during data", en, 8);
    check("R3 so_en after deselect", so_en, 0);

    frame(ins(4'h1, DEV, 2'd1), 8'd200, 16, 1, -1, -1, rd, en);
    m_wip[1] = 6'd63;
    check("R5 saturate with wp low", wiper, {m_wip[1], m_wip[0]});

    frame(ins(4'h1, DEV ^ 2'b01, 2'd0), 8'd5, 16, 0, -1, -1, rd, en);
    check("R4 mismatch write ignored", wiper, {m_wip[1], m_wip[0]});
    frame(ins(4'h3, DEV ^ 2'b11, 2'd0), 8'h00, 16, 0, -1, -1, rd, en);
    check("R4 mismatch read not driven", en, 0);

    frame(ins(4'h1, DEV, 2'd2), 8'd7, 16, 0, -1, -1, rd, en);
    check("R10 pot select 2 ignored", wiper, {m_wip[1], m_wip[0]});
    frame(ins(4'hF, DEV, 2'd0), 8'd7, 16, 0, -1, -1, rd, en);
    check("R10 unknown op ignored", wiper, {m_wip[1], m_wip[0]});

    frame(ins(4'h2, DEV, 2'd0), 8'd45, 16, 0, -1, -1, rd, en);
    check("R6 busy after commit", busy, 1);
    check("R3 standby low while busy", standby, 0);
    wp_n = 1'b0;
    tick(10);
    wp_n = 1'b1;
    frame(ins(4'h5, DEV, 2'd0), 8'h00, 16, 0, -1, -1, rd, en);
    check("R8 status busy", rd, 8'h01);
    frame(ins(4'h1, DEV, 2'd0), 8'd20, 16, 0, -1, -1, rd, en);
    check("R8 wiper write rejected while busy", wiper, {m_wip[1], m_wip[0]});
    tick(WR + 20);
    check("R6 busy cleared", busy, 0);
    check("R3 standby idle", standby, 1);
    m_nv[0] = 6'd45;
    frame(ins(4'h4, DEV, 2'd0), 8'h00, 16, 0, -1, -1, rd, en);
    check("R7 nv write kept despite wp while busy", rd, 8'd45);

    frame(ins(4'h2, DEV, 2'd1), 8'd9, 16, 0, -1, -1, rd, en);
    m_nv[1] = 6'd9;
    frame(ins(4'h2, DEV, 2'd0), 8'd3, 16, 0, -1, -1, rd, en);
    tick(WR + 20);
    frame(ins(4'h4, DEV, 2'd0), 8'h00, 16, 0, -1, -1, rd, en);
    check("R8 nv write rejected while busy", rd, 8'd45);
    frame(ins(4'h4, DEV, 2'd1), 8'h00, 16, 0, -1, -1, rd, en);
    check("R6 nv pot1 value", rd, 8'd9);
    frame(ins(4'h5, DEV, 2'd0), 8'h00, 16, 0, -1, -1, rd, en);
    check("R8 status idle", rd, 8'h00);

    frame(ins(4'h2, DEV, 2'd0), 8'd11, 16, 1, -1, -1, rd, en);
    check("R7 wp low blocks nv", busy, 0);
    frame(ins(4'h2, DEV, 2'd0), 8'd12, 16, 0, 5, -1, rd, en);
    check("R7 wp pulse aborts", busy, 0);
    frame(ins(4'h2, DEV, 2'd0), 8'd13, 17, 0, -1, -1, rd, en);
    check("R6 17 bits no commit", busy, 0);
    frame(ins(4'h2, DEV, 2'd0), 8'd14, 15, 0, -1, -1, rd, en);
    check("R6 15 bits no commit", busy, 0);
    frame(ins(4'h4, DEV, 2'd0), 8'h00, 16, 0, -1, -1, rd, en);
    check("R7 nv unchanged after blocks", rd, 8'd45);

    frame(ins(4'h1, DEV, 2'd1), 8'd33, 16, 0, -1, 5, rd, en);
    m_wip[1] = 6'd33;
    check("R9 write resumes after pause", wiper, {m_wip[1], m_wip[0]});
    frame(ins(4'h3, DEV, 2'd1), 8'h00, 16, 0, -1, 11, rd, en);
    check("R9 read resumes after pause", rd, 8'd33);

    for (int n = 0; n < 120; n++) begin
      logic [3:0] op;
      logic [1:0] a, p;
      logic [7:0] d, exp;
      bit hit, wpl, commit;
      int h;
      case ($urandom % 6)
        0: op = 4'h1; 1: op = 4'h2; 2: op = 4'h3;
        3: op = 4'h4; 4: op = 4'h5; default: op = 4'hF;
      endcase
      a = ($urandom % 4 != 0) ? DEV : DEV ^ 2'(1 + $urandom % 3);
      p = 2'($urandom % 3);
      d = 8'($urandom);
      wpl = ($urandom % 7 == 0);
      h = ($urandom % 5 == 0) ? int'($urandom % 16) : -1;
      hit = (a == DEV) && (p < 2'd2);
      commit = 0;
      frame(ins(op, a, p), d, 16, wpl, -1, h, rd, en);
      exp = '0;
      if (hit && op == 4'h1) m_wip[p[0]] = sat(d);
      if (hit && op == 4'h2 && !wpl) begin m_nv[p[0]] = sat(d); commit = 1; end
      if (hit && op == 4'h3) exp = {2'b00, m_wip[p[0]]};
      if (hit && op == 4'h4) exp = {2'b00, m_nv[p[0]]};
      if (hit && (op == 4'h3 || op == 4'h4 || op == 4'h5)) begin
        check("R2 random read data", rd, exp);
        check("R2 random read enable", en, 8);
      end else check("R4 random no drive", en, 0);
      check("R6 random commit", busy, commit);
      check("R5 random taps", wiper, {m_wip[1], m_wip[0]});
      if (commit) tick(WR + 20);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule